// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that copies data word by word between two addresses and then, when told to, follows a linked list of descriptors in memory. Software loads the first transfer straight into the channel registers: the link word, the byte count, the source, the destination and the configuration word. Setting the enable bit of the configuration word starts the channel. Each later node is read from a 32-byte, 32-byte-aligned descriptor. Byte offset 0 of a descriptor holds the link, offset 16 the byte count, offset 20 the source, offset 24 the destination and offset 28 the configuration word. Offsets 4 to 12 are unused.

Data moves through one request port with a valid/ready handshake. Every accepted request, read or write, gets exactly one response, which may carry an error flag. Only one request is in flight at a time. The channel raises one-cycle pulses toward an interrupt block: one when a node that asks for it finishes, one when the whole chain finishes, and one when an error response aborts the channel. A chain whose last link points back to its first descriptor runs without end. This gives a ring buffer with a period pulse at every flagged node. Software pauses the channel by clearing the enable bit and resumes it by setting the bit again.

Top module: `ll_dma_channel`

## Requirements
- R1: After reset, busy, all three pulse outputs and the request valid are low, and every register read index (0 to 5) returns zero.
- R2: Register indices are 0 link, 1 byte count, 2 source, 3 destination, 4 configuration, and 5 the read-only remaining count. Index 5 gives the low 16 bits of the remaining count, zero-extended. A stored count keeps only bits 12:2 of the written value, so at most 0x1ffc bytes move per node.
- R3: Writing the configuration word with bit 0 set while idle raises busy and starts the loaded node. Each beat reads one 32-bit word at the source and writes it at the destination, until the count reaches zero. After each beat the source address grows by 4 when configuration bit 31 is set, and the destination address grows by 4 when bit 30 is set. Otherwise that address stays fixed.
- R4: When a node ends and bit 1 of its link is set, the channel reads the descriptor at the link address with bits 4:0 cleared. It issues five reads, at byte offsets 0, 16, 20, 24 and 28, and loads link, count, source, destination and configuration from them. Bit 0 of a fetched configuration word is not taken. The link register then shows the link of the node in progress.
- R5: When a node ends and bit 1 of its link is clear (a zero link included), the chain-done pulse is high for one cycle. Busy falls in that same cycle, and configuration bit 0 reads back as zero.
- R6: A finishing node whose configuration bit 1 is set gives a one-cycle node pulse, and this includes the last node of a chain.
- R7: A chain whose last link leads back to its first descriptor repeats without end. It gives a node pulse at every flagged node and never a chain-done pulse.
- R8: Clearing configuration bit 0 while busy lets the request already in flight finish. After that no new request is issued, and the remaining count holds still while busy stays high. Setting the bit again continues from the point where the channel stopped.
- R9: While busy, writes to the link, count, source and destination registers are ignored. A configuration write while busy changes only bit 0.
- R10: An error response, to a data read, a data write or a descriptor fetch, stops the channel. The error pulse is high for one cycle and busy falls in that same cycle. Configuration bit 0 clears, and no chain-done pulse appears.
- R11: A node with a zero count finishes without any memory request.
- R12: Once the request valid is high it stays high, with address and direction unchanged, until ready is seen. A new request is issued only after the response to the previous one has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 3 | Register index for the write |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_idx | input | 3 | Register index for the read |
| reg_rd_data | output | 32 | Read data for the selected register, combinational |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | ADDR_W | Byte address of the request |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response for the request in flight |
| mem_rsp_data | input | 32 | Read data of the response |
| mem_rsp_err | input | 1 | Error flag of the response |
| busy | output | 1 | The channel holds an unfinished chain |
| node_irq | output | 1 | One-cycle pulse when a flagged node finishes |
| chain_irq | output | 1 | One-cycle pulse when the chain finishes |
| err_irq | output | 1 | One-cycle pulse when an error response aborts the channel |

## Verification
The bench builds the channel with its default parameters: 32-bit addresses, a 13-bit count and a 16-bit remaining-count view. The 13-bit count puts the 0x1ffc ceiling and the masking of the low bits within reach through plain register writes. The full 32-bit address space lets the memory model answer with errors above 0x10000 while holding real data in a 4 KiB window. Inside that window are source and destination areas, descriptor chains, a two-node ring and all three error paths. The model varies ready and the response latency at random, so the hold-until-ready rule, pause and resume are tested with uneven timing.

// File: rtl/ll_dma_pkg.sv
package ll_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_REQ,
        ST_FETCH_WAIT,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_NODE_END
    } dma_state_e;

    localparam logic [2:0] REG_LINK   = 3'd0;
    localparam logic [2:0] REG_COUNT  = 3'd1;
    localparam logic [2:0] REG_SRC    = 3'd2;
    localparam logic [2:0] REG_DST    = 3'd3;
    localparam logic [2:0] REG_CFG    = 3'd4;
    localparam logic [2:0] REG_CURCNT = 3'd5;

    localparam int unsigned CFG_EN_BIT      = 0;
    localparam int unsigned CFG_NODE_BIT    = 1;
    localparam int unsigned CFG_DST_INC_BIT = 30;
    localparam int unsigned CFG_SRC_INC_BIT = 31;
    localparam int unsigned LINK_CHAIN_BIT  = 1;

endpackage

// File: rtl/ll_dma_addr_step.sv
module ll_dma_addr_step #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned STEP   = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] addr_o
);
    always_comb begin
        addr_o = inc_i ? addr_i + ADDR_W'(STEP) : addr_i;
    end
endmodule

// File: rtl/ll_dma_fetch_seq.sv
module ll_dma_fetch_seq #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned SLOT_W    = 3,
    parameter int unsigned LAST_SLOT = 4,
    parameter int unsigned SKIP      = 3
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    localparam int unsigned IDX_W = SLOT_W + 1;
    logic [IDX_W-1:0] word_idx;

    // slot 0 is the link word; later slots skip the unused words
    always_comb begin
        if (slot_i == '0) word_idx = '0;
        else              word_idx = IDX_W'(slot_i) + IDX_W'(SKIP);
        addr_o = base_i + (ADDR_W'(word_idx) << 2);
        last_o = (slot_i == SLOT_W'(LAST_SLOT));
    end
endmodule

// File: rtl/ll_dma_reg_view.sv
module ll_dma_reg_view #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned CNT_W    = 13,
    parameter int unsigned CURCNT_W = 16
) (
    input  logic [2:0]        idx_i,
    input  logic [31:0]       link_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [31:0]       cfg_i,
    output logic [31:0]       data_o
);
    import ll_dma_pkg::*;
    logic [CURCNT_W-1:0] cur_view;

    always_comb begin
        cur_view = CURCNT_W'(cnt_i);
        case (idx_i)
            REG_LINK:   data_o = link_i;
            REG_COUNT:  data_o = 32'(cnt_i);
            REG_SRC:    data_o = 32'(src_i);
            REG_DST:    data_o = 32'(dst_i);
            REG_CFG:    data_o = cfg_i;
            REG_CURCNT: data_o = 32'(cur_view);
            default:    data_o = '0;
        endcase
    end
endmodule

// File: rtl/ll_dma_channel.sv
module ll_dma_channel
    import ll_dma_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned CNT_W    = 13,
    parameter int unsigned CURCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_idx,
    input  logic [31:0]       reg_wr_data,
    input  logic [2:0]        reg_rd_idx,
    output logic [31:0]       reg_rd_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [31:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              busy,
    output logic              node_irq,
    output logic              chain_irq,
    output logic              err_irq
);
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned BEAT_BYTES = WORD_W / 8;
    localparam int unsigned DESC_LSB   = 5;
    localparam int unsigned SLOT_W     = 3;
    localparam int unsigned LAST_SLOT  = 4;
    localparam int unsigned N_PTR      = 2;

    typedef struct packed {
        dma_state_e          st;
        logic                busy;
        logic [WORD_W-1:0]   link;
        logic [CNT_W-1:0]    cnt;
        logic [ADDR_W-1:0]   src;
        logic [ADDR_W-1:0]   dst;
        logic [ADDR_W-1:0]   base;
        logic [WORD_W-1:0]   cfg;
        logic [WORD_W-1:0]   data;
        logic [SLOT_W-1:0]   slot;
        logic                hold;
        logic                node_p;
        logic                chain_p;
        logic                err_p;
    } ctx_t;

    ctx_t q, d;

    function automatic logic [CNT_W-1:0] trim_cnt(input logic [WORD_W-1:0] w);
        trim_cnt = w[CNT_W-1:0] & ~CNT_W'(BEAT_BYTES - 1);
    endfunction

    // address stepping for source (0) and destination (1)
    logic [ADDR_W-1:0] ptr_cur [N_PTR];
    logic              ptr_inc [N_PTR];
    logic [ADDR_W-1:0] ptr_nxt [N_PTR];

    assign ptr_cur[0] = q.src;
    assign ptr_cur[1] = q.dst;
    assign ptr_inc[0] = q.cfg[CFG_SRC_INC_BIT];
    assign ptr_inc[1] = q.cfg[CFG_DST_INC_BIT];

    for (genvar g = 0; g < N_PTR; g++) begin : g_step
        ll_dma_addr_step #(
            .ADDR_W(ADDR_W),
            .STEP  (BEAT_BYTES)
        ) u_step (
            .addr_i(ptr_cur[g]),
            .inc_i (ptr_inc[g]),
            .addr_o(ptr_nxt[g])
        );
    end

    logic [ADDR_W-1:0] fetch_addr;
    logic              fetch_last;

    ll_dma_fetch_seq #(
        .ADDR_W   (ADDR_W),
        .SLOT_W   (SLOT_W),
        .LAST_SLOT(LAST_SLOT),
        .SKIP     (3)
    ) u_fetch (
        .base_i(q.base),
        .slot_i(q.slot),
        .addr_o(fetch_addr),
        .last_o(fetch_last)
    );

    ll_dma_reg_view #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .CURCNT_W(CURCNT_W)
    ) u_view (
        .idx_i (reg_rd_idx),
        .link_i(q.link),
        .cnt_i (q.cnt),
        .src_i (q.src),
        .dst_i (q.dst),
        .cfg_i (q.cfg),
        .data_o(reg_rd_data)
    );

    logic req_state;
    logic req_fire;

    always_comb begin
        req_state = (q.st == ST_FETCH_REQ) || (q.st == ST_RD_REQ) || (q.st == ST_WR_REQ);
        mem_req_valid = req_state && (q.cfg[CFG_EN_BIT] || q.hold);
        mem_req_write = (q.st == ST_WR_REQ);
        case (q.st)
            ST_FETCH_REQ: mem_req_addr = fetch_addr;
            ST_WR_REQ:    mem_req_addr = q.dst;
            default:      mem_req_addr = q.src;
        endcase
        mem_req_wdata = q.data;
        req_fire = mem_req_valid && mem_req_ready;
    end

    always_comb begin
        d         = q;
        d.node_p  = 1'b0;
        d.chain_p = 1'b0;
        d.err_p   = 1'b0;
        d.hold    = mem_req_valid && !mem_req_ready;

        case (q.st)
            ST_FETCH_REQ: if (req_fire) d.st = ST_FETCH_WAIT;
            ST_RD_REQ:    if (req_fire) d.st = ST_RD_WAIT;
            ST_WR_REQ:    if (req_fire) d.st = ST_WR_WAIT;
            ST_FETCH_WAIT: begin
                if (mem_rsp_valid) begin
                    case (q.slot)
                        3'd0:    d.link = mem_rsp_data;
                        3'd1:    d.cnt  = trim_cnt(mem_rsp_data);
                        3'd2:    d.src  = ADDR_W'(mem_rsp_data);
                        3'd3:    d.dst  = ADDR_W'(mem_rsp_data);
                        default: d.cfg  = {mem_rsp_data[WORD_W-1:1], q.cfg[CFG_EN_BIT]};
                    endcase
                    if (fetch_last) begin
                        d.slot = '0;
                        d.st   = (q.cnt == '0) ? ST_NODE_END : ST_RD_REQ;
                    end else begin
                        d.slot = q.slot + SLOT_W'(1);
                        d.st   = ST_FETCH_REQ;
                    end
                end
            end
            ST_RD_WAIT: begin
                if (mem_rsp_valid) begin
                    d.data = mem_rsp_data;
                    d.st   = ST_WR_REQ;
                end
            end
            ST_WR_WAIT: begin
                if (mem_rsp_valid) begin
                    d.cnt = q.cnt - CNT_W'(BEAT_BYTES);
                    d.src = ptr_nxt[0];
                    d.dst = ptr_nxt[1];
                    d.st  = (q.cnt == CNT_W'(BEAT_BYTES)) ? ST_NODE_END : ST_RD_REQ;
                end
            end
            ST_NODE_END: begin
                d.node_p = q.cfg[CFG_NODE_BIT];
                if (q.link[LINK_CHAIN_BIT]) begin
                    d.base = {q.link[ADDR_W-1:DESC_LSB], DESC_LSB'(0)};
                    d.slot = '0;
                    d.st   = ST_FETCH_REQ;
                end else begin
                    d.chain_p           = 1'b1;
                    d.busy              = 1'b0;
                    d.cfg[CFG_EN_BIT]   = 1'b0;
                    d.st                = ST_IDLE;
                end
            end
            default: ;
        endcase

        // any error response ends the chain at once
        if (mem_rsp_valid && mem_rsp_err &&
            (q.st == ST_FETCH_WAIT || q.st == ST_RD_WAIT || q.st == ST_WR_WAIT)) begin
            d                 = q;
            d.node_p          = 1'b0;
            d.chain_p         = 1'b0;
            d.hold            = 1'b0;
            d.slot            = '0;
            d.err_p           = 1'b1;
            d.busy            = 1'b0;
            d.cfg[CFG_EN_BIT] = 1'b0;
            d.st              = ST_IDLE;
        end

        if (reg_wr_en) begin
            if (!q.busy) begin
                case (reg_wr_idx)
                    REG_LINK:  d.link = reg_wr_data;
                    REG_COUNT: d.cnt  = trim_cnt(reg_wr_data);
                    REG_SRC:   d.src  = ADDR_W'(reg_wr_data);
                    REG_DST:   d.dst  = ADDR_W'(reg_wr_data);
                    REG_CFG: begin
                        d.cfg = reg_wr_data;
                        if (reg_wr_data[CFG_EN_BIT]) begin
                            d.busy = 1'b1;
                            d.st   = (q.cnt == '0) ? ST_NODE_END : ST_RD_REQ;
                        end
                    end
                    default: ;
                endcase
            end else if (reg_wr_idx == REG_CFG) begin
                d.cfg[CFG_EN_BIT] = reg_wr_data[CFG_EN_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy      = q.busy;
    assign node_irq  = q.node_p;
    assign chain_irq = q.chain_p;
    assign err_irq   = q.err_p;

endmodule

// File: rtl/ll_dma_channel_chk.sv
module ll_dma_channel_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              node_irq,
    input logic              chain_irq,
    input logic              err_irq
);
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid);

    // R5
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (chain_irq || err_irq));

    // R10
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (!chain_irq && !busy));

    // R6
    node_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        node_irq |=> !node_irq);

    // R5
    chain_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_irq |=> !chain_irq);
endmodule

bind ll_dma_channel ll_dma_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr (mem_req_addr),
    .node_irq     (node_irq),
    .chain_irq    (chain_irq),
    .err_irq      (err_irq)
);

// File: tb/ll_dma_channel_tb.sv
module ll_dma_channel_tb;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned MEM_WORDS = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr_en = 1'b0;
    logic [2:0] reg_wr_idx = '0;
    logic [31:0] reg_wr_data = '0;
    logic [2:0] reg_rd_idx = '0;
    logic [31:0] reg_rd_data;
    logic mem_req_valid, mem_req_write;
    logic mem_req_ready = 1'b0;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic mem_rsp_err = 1'b0;
    logic busy, node_irq, chain_irq, err_irq;

    always #5 clk = ~clk;

    ll_dma_channel u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
        .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .busy(busy), .node_irq(node_irq), .chain_irq(chain_irq), .err_irq(err_irq)
    );

    // ---------------- memory model ----------------
    logic [31:0] mem [MEM_WORDS];
    logic        pend = 1'b0;
    int          dly = 0;
    logic [ADDR_W-1:0] p_addr = '0;
    logic        p_err = 1'b0;

    function automatic logic bad_addr(input logic [ADDR_W-1:0] a);
        return a[31:16] != 16'h0;
    endfunction

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (!rst_n) begin
            mem_req_ready <= 1'b0;
            pend <= 1'b0;
        end else begin
            if (pend) begin
                if (dly == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_err   <= p_err;
                    mem_rsp_data  <= mem[p_addr[11:2]];
                    pend <= 1'b0;
                end else begin
                    dly <= dly - 1;
                end
            end else if (mem_req_valid && mem_req_ready) begin
                p_addr <= mem_req_addr;
                p_err  <= bad_addr(mem_req_addr);
                if (mem_req_write && !bad_addr(mem_req_addr))
                    mem[mem_req_addr[11:2]] <= mem_req_wdata;
                pend <= 1'b1;
                dly  <= int'($urandom % 3);
            end
            mem_req_ready <= ($urandom % 4) != 0;
        end
    end

    // ---------------- event counters ----------------
    int n_node = 0, n_chain = 0, n_err = 0, n_acc = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (node_irq)  n_node++;
            if (chain_irq) n_chain++;
            if (err_irq)   n_err++;
            if (mem_req_valid && mem_req_ready) n_acc++;
        end
    end

    int n_chk = 0, n_fail = 0;
    logic done = 1'b0;
    int b_node, b_chain, b_err, b_acc;
    logic [31:0] ref_src [256];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_idx = idx; reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] v);
        reg_rd_idx = idx;
        #1;
        v = reg_rd_data;
    endtask

    task automatic snap();
        b_node = n_node; b_chain = n_chain; b_err = n_err; b_acc = n_acc;
    endtask

    task automatic wait_idle(input string req);
        int t = 0;
        while (busy && t < 20000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        chk(req, {31'd0, busy}, 32'd0);
    endtask

    task automatic fill_src();
        for (int i = 0; i < 256; i++) begin
            mem[i] = $urandom;
            ref_src[i] = mem[i];
        end
        for (int i = 256; i < 512; i++) mem[i] = 32'hEEEE_0000 | i;
    endtask

    task automatic put_desc(input int a, input logic [31:0] lk, input logic [31:0] cn,
                            input logic [31:0] s, input logic [31:0] dd, input logic [31:0] cf);
        mem[a/4]     = lk;
        mem[a/4 + 1] = 32'hBAD0_0001;
        mem[a/4 + 2] = 32'hBAD0_0002;
        mem[a/4 + 3] = 32'hBAD0_0003;
        mem[a/4 + 4] = cn;
        mem[a/4 + 5] = s;
        mem[a/4 + 6] = dd;
        mem[a/4 + 7] = cf;
    endtask

    // expected destination word for an incrementing copy
    function automatic logic [31:0] exp_word(input int src_w, input int k, input logic sinc);
        return sinc ? ref_src[src_w + k] : ref_src[src_w];
    endfunction

    task automatic check_copy(input string req, input int src_w, input int dst_w, input int words);
        for (int k = 0; k < words; k++)
            chk(req, mem[dst_w + k], exp_word(src_w, k, 1'b1));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v, v2;
        int s_w, d_w, words;
        logic flag;
        int seed;
        seed = int'($urandom(32'h5EED_1234));
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 pulses", {29'd0, node_irq, chain_irq, err_irq}, 32'd0);
        chk("R1 valid", {31'd0, mem_req_valid}, 32'd0);
        for (int i = 0; i < 6; i++) begin
            rd(3'(i), v);
            chk("R1 regs", v, 32'd0);
        end

        // R2 count masking and readback
        wr(3'd1, 32'h0000_FFFF);
        rd(3'd5, v);  chk("R2 curcnt cap", v, 32'h1FFC);
        rd(3'd1, v);  chk("R2 count cap", v, 32'h1FFC);
        wr(3'd1, 32'h0000_0013);
        rd(3'd5, v);  chk("R2 count low bits", v, 32'h10);
        wr(3'd2, 32'h0000_0ABC);
        rd(3'd2, v);  chk("R2 src", v, 32'h0ABC);
        wr(3'd5, 32'h0000_0040);
        rd(3'd5, v);  chk("R2 curcnt read-only", v, 32'h10);

        // R3 R5 R6 random single nodes
        for (int it = 0; it < 4; it++) begin
            fill_src();
            words = 1 + int'($urandom % 16);
            s_w = int'($urandom % 64);
            d_w = 256 + int'($urandom % 64);
            flag = 1'($urandom % 2);
            snap();
            wr(3'd0, 32'h0);
            wr(3'd1, 32'(words * 4));
            wr(3'd2, 32'(s_w * 4));
            wr(3'd3, 32'(d_w * 4));
            wr(3'd4, 32'hC0FF_3001 | {30'd0, flag, 1'b0});
            wait_idle("R3 finish");
            check_copy("R3 data", s_w, d_w, words);
            chk("R5 chain pulse", 32'(n_chain - b_chain), 32'd1);
            chk("R6 node pulse", 32'(n_node - b_node), 32'(flag));
            chk("R3 requests", 32'(n_acc - b_acc), 32'(2 * words));
            rd(3'd5, v); chk("R3 curcnt end", v, 32'd0);
            rd(3'd4, v); chk("R5 enable clear", {31'd0, v[0]}, 32'd0);
        end

        // R3 fixed source
        fill_src();
        wr(3'd0, 0); wr(3'd1, 16); wr(3'd2, 32'd8); wr(3'd3, 32'h500);
        wr(3'd4, 32'h4000_0001);
        wait_idle("R3 fixed src");
        for (int k = 0; k < 4; k++) chk("R3 fixed src data", mem[320 + k], ref_src[2]);
        // R3 fixed destination
        fill_src();
        wr(3'd0, 0); wr(3'd1, 16); wr(3'd2, 32'd0); wr(3'd3, 32'h600);
        wr(3'd4, 32'h8000_0001);
        wait_idle("R3 fixed dst");
        chk("R3 fixed dst last", mem[384], ref_src[3]);
        chk("R3 fixed dst neighbour", mem[385], 32'hEEEE_0000 | 32'd385);

        // R4 R5 R6 three-node chain
        fill_src();
        put_desc(32'h800, 32'h822, 32'd20, 32'h40, 32'h440, 32'hC000_0000);
        put_desc(32'h820, 32'h0,   32'd12, 32'h80, 32'h480, 32'hC000_0002);
        snap();
        wr(3'd0, 32'h803); wr(3'd1, 8); wr(3'd2, 0); wr(3'd3, 32'h400);
        wr(3'd4, 32'hC000_0003);
        wait_idle("R4 chain");
        check_copy("R4 data node0", 0, 256, 2);
        check_copy("R4 data node1", 16, 272, 5);
        check_copy("R4 data node2", 32, 288, 3);
        chk("R4 requests", 32'(n_acc - b_acc), 32'(2 * 10 + 10));
        chk("R6 chain nodes", 32'(n_node - b_node), 32'd2);
        chk("R5 chain once", 32'(n_chain - b_chain), 32'd1);
        rd(3'd0, v); chk("R4 link of last node", v, 32'd0);

        // R9 R8 writes while busy, pause and resume
        fill_src();
        snap();
        wr(3'd0, 0); wr(3'd1, 256); wr(3'd2, 0); wr(3'd3, 32'h400);
        wr(3'd4, 32'hC000_0001);
        repeat (20) @(negedge clk);
        wr(3'd0, 32'h1234); wr(3'd1, 8); wr(3'd2, 32'h100);
        rd(3'd0, v); chk("R9 link ignored", v, 32'd0);
        wr(3'd4, 32'h0);
        repeat (20) @(negedge clk);
        rd(3'd5, v); b_acc = n_acc;
        repeat (40) @(negedge clk);
        rd(3'd5, v2);
        chk("R8 count held", v2, v);
        chk("R8 no requests", 32'(n_acc - b_acc), 32'd0);
        chk("R8 busy while paused", {31'd0, busy}, 32'd1);
        wr(3'd4, 32'h1);
        wait_idle("R8 resume");
        check_copy("R8 R9 data", 0, 256, 64);
        chk("R8 chain", 32'(n_chain - b_chain), 32'd1);

        // R7 cyclic ring, R11 zero-count start node
        fill_src();
        put_desc(32'h900, 32'h922, 32'd16, 32'h0,  32'h400, 32'hC000_0002);
        put_desc(32'h920, 32'h902, 32'd16, 32'h10, 32'h410, 32'hC000_0002);
        snap();
        wr(3'd0, 32'h902); wr(3'd1, 0); wr(3'd4, 32'hC000_0001);
        for (int t = 0; t < 20000 && (n_node - b_node) < 6; t++) @(negedge clk);
        chk("R7 node pulses", {31'd0, 1'((n_node - b_node) >= 6)}, 32'd1);
        chk("R7 no chain pulse", 32'(n_chain - b_chain), 32'd0);
        chk("R7 busy", {31'd0, busy}, 32'd1);
        mem[32'h920 / 4] = 32'h0;
        wait_idle("R7 ring closed");
        chk("R7 ends once", 32'(n_chain - b_chain), 32'd1);
        check_copy("R7 data", 0, 256, 8);

        // R11 zero count, no traffic
        snap();
        wr(3'd0, 0); wr(3'd1, 0); wr(3'd4, 32'h3);
        wait_idle("R11 zero");
        chk("R11 no requests", 32'(n_acc - b_acc), 32'd0);
        chk("R11 chain", 32'(n_chain - b_chain), 32'd1);
        chk("R11 node", 32'(n_node - b_node), 32'd1);

        // R10 read error
        snap();
        wr(3'd0, 0); wr(3'd1, 16); wr(3'd2, 32'h0002_0000); wr(3'd3, 32'h400);
        wr(3'd4, 32'hC000_0001);
        wait_idle("R10 read err");
        chk("R10 read err pulse", 32'(n_err - b_err), 32'd1);
        chk("R10 no chain", 32'(n_chain - b_chain), 32'd0);
        chk("R10 read requests", 32'(n_acc - b_acc), 32'd1);
        rd(3'd4, v); chk("R10 enable clear", {31'd0, v[0]}, 32'd0);
        // R10 write error
        snap();
        wr(3'd0, 0); wr(3'd1, 16); wr(3'd2, 0); wr(3'd3, 32'h0003_0000);
        wr(3'd4, 32'hC000_0001);
        wait_idle("R10 write err");
        chk("R10 write err pulse", 32'(n_err - b_err), 32'd1);
        chk("R10 write requests", 32'(n_acc - b_acc), 32'd2);
        // R10 fetch error
        snap();
        wr(3'd0, 32'h0004_0002); wr(3'd1, 0); wr(3'd4, 32'h1);
        wait_idle("R10 fetch err");
        chk("R10 fetch err pulse", 32'(n_err - b_err), 32'd1);
        chk("R10 fetch no chain", 32'(n_chain - b_chain), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule